// File: doc/BRIEF.md
# Immediate-Operand Instruction Executor

This block runs a small set of 32-bit instructions that each carry a four-byte immediate operand. Instruction bytes enter one per accepted cycle on a valid/ready byte stream. The block holds eight 32-bit general registers and three status flags: sign, zero and signed overflow. It decodes the opcode and, where the opcode needs one, an operand-selector byte. It then gathers the immediate and carries out an add, subtract, and, or, xor, compare, copy or stack push.

The destination is either a register or the 32-bit word in data memory that a register points to. Memory is reached through a simple synchronous port. A read returns its data on the cycle after the request, and a write takes effect at the clock edge where it is requested. A diagnostic select input shows any register's contents, so that an integrating environment or a bench can observe the results. An opcode, sub-operation or selector form that the block does not support raises a fault. The fault stops the block until it is reset.

Top module: `imm_exec_core`

## Requirements
- R1: The immediate is the four bytes that follow the opcode, and the selector byte when there is one. They are taken in little-endian order, so bytes 0a 0b 0c 0d give 0x0d0c0b0a.
- R2: Opcode 0x81 is followed by a selector byte, and selector bits [5:3] choose the operation: 0 add, 1 or, 4 and, 5 subtract, 6 xor, 7 compare. The register number is held in selector bits [2:0].
- R3: If selector bits [7:6] are 11, the destination is the register itself. If they are 00, the destination is the memory word at the address that register holds. That word is read, modified and written back, with only one memory access outstanding at a time.
- R4: The one-byte forms 0x0d (or), 0x25 (and), 0x2d (subtract), 0x35 (xor) and 0x3d (compare) take no selector byte and act on register 0.
- R5: Compare computes destination minus immediate and sets the flags from that result. It writes nothing back to a register or to memory.
- R6: After add, subtract and compare, the sign flag is result bit 31 and the zero flag is set when the result is zero. The overflow flag is set when the true signed result does not fit in 32 bits. And, or and xor set the sign and zero flags the same way and clear the overflow flag.
- R7: Opcodes 0xb8 to 0xbf copy the immediate into the register numbered by opcode bits [2:0]. Registers are numbered 0 to 7, and register 4 is the stack pointer.
- R8: Opcode 0xc7 takes a selector byte and copies the immediate into the register or memory word that the selector names. Selector bits [5:3] have no effect.
- R9: Opcode 0x68 first lowers register 4 by 4. It then writes the immediate to memory at the new value of register 4.
- R10: Once the last byte of an instruction is accepted, in_ready stays low until the instruction retires. The memory port is never active while in_ready is high.
- R11: The fault output rises and stays high, and in_ready stays low, until reset, on any of these: an unknown opcode, a 0x81 sub-operation of 2 or 3, a selector with bits [7:6] of 01 or 10, or a memory selector with bits [2:0] of 4 or 5.
- R12: Reset clears all registers, all flags, the fault output and the decode state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| peek_sel | input | 3 | Register number to display |
| peek_data | output | 32 | Contents of the selected register |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_o | output | 1 | Signed overflow flag |
| fault | output | 1 | Sticky fault indication |

## Verification
The block has no parameters, so the bench builds the single 32-bit, eight-register configuration. It exercises every opcode form that the block decodes, on register and memory destinations. Signed-overflow corner cases are driven from the 0x7fffffff and 0x80000000 boundaries. A bench-side memory model counts write requests, so the bench can confirm that compare stores nothing. Each class of fault is injected in turn and then cleared by reset, which shows that the fault holds and that reset wipes all state.

// File: rtl/imm_exec_core.sv
module imm_exec_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic [2:0]  peek_sel,
  output logic [31:0] peek_data,
  output logic        flag_s,
  output logic        flag_z,
  output logic        flag_o,
  output logic        fault
);

  localparam int          NREG   = 8;
  localparam logic [2:0]  SP_IDX = 3'd4;
  localparam logic [2:0]  OP_ADD = 3'd0;
  localparam logic [2:0]  OP_OR  = 3'd1;
  localparam logic [2:0]  OP_AND = 3'd4;
  localparam logic [2:0]  OP_SUB = 3'd5;
  localparam logic [2:0]  OP_XOR = 3'd6;
  localparam logic [2:0]  OP_CMP = 3'd7;

  typedef enum logic [2:0] {
    S_OP, S_SEL, S_IMM, S_EXEC, S_RD, S_RWAIT, S_WB, S_HALT
  } state_t;

  typedef enum logic [1:0] {K_ALU, K_MOV, K_PUSH} kind_t;

  state_t      st;
  kind_t       kind;
  logic [2:0]  alu_op;
  logic [2:0]  dst;
  logic        to_mem;
  logic [31:0] imm;
  logic [1:0]  cnt;
  logic [31:0] maddr;
  logic [31:0] wdat;
  logic [31:0] rf [NREG];

  logic [31:0] a_in, res;
  logic        ovf, sel_bad;
  logic [31:0] sp_dec;

  assign in_ready  = (st == S_OP) || (st == S_SEL) || (st == S_IMM);
  assign mem_req   = (st == S_RD) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = maddr;
  assign mem_wdata = wdat;
  assign peek_data = rf[peek_sel];
  assign fault     = (st == S_HALT);
  assign sp_dec    = rf[SP_IDX] - 32'd4;

  assign a_in = (st == S_RWAIT) ? mem_rdata : rf[dst];

  always_comb begin
    res = a_in;
    ovf = 1'b0;
    case (alu_op)
      OP_ADD: begin
        res = a_in + imm;
        ovf = (a_in[31] == imm[31]) && (res[31] != a_in[31]);
      end
      OP_SUB, OP_CMP: begin
        res = a_in - imm;
        ovf = (a_in[31] != imm[31]) && (res[31] != a_in[31]);
      end
      OP_OR:  res = a_in | imm;
      OP_AND: res = a_in & imm;
      OP_XOR: res = a_in ^ imm;
      default: res = a_in;
    endcase
  end

  assign sel_bad = (in_byte[7:6] == 2'b01) || (in_byte[7:6] == 2'b10) ||
                   ((in_byte[7:6] == 2'b00) && (in_byte[2:1] == 2'b10)) ||
                   ((kind == K_ALU) && (in_byte[5:4] == 2'b01));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_OP;
      kind   <= K_ALU;
      alu_op <= 3'd0;
      dst    <= 3'd0;
      to_mem <= 1'b0;
      imm    <= '0;
      cnt    <= '0;
      maddr  <= '0;
      wdat   <= '0;
      flag_s <= 1'b0;
      flag_z <= 1'b0;
      flag_o <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_OP: if (in_valid) begin
          cnt    <= '0;
          to_mem <= 1'b0;
          if (in_byte == 8'h81) begin
            kind <= K_ALU;
            st   <= S_SEL;
          end else if (in_byte == 8'hc7) begin
            kind <= K_MOV;
            st   <= S_SEL;
          end else if (in_byte == 8'h0d || in_byte == 8'h25 || in_byte == 8'h2d ||
                       in_byte == 8'h35 || in_byte == 8'h3d) begin
            kind   <= K_ALU;
            alu_op <= in_byte[5:3];
            dst    <= 3'd0;
            st     <= S_IMM;
          end else if (in_byte[7:3] == 5'b10111) begin
            kind <= K_MOV;
            dst  <= in_byte[2:0];
            st   <= S_IMM;
          end else if (in_byte == 8'h68) begin
            kind <= K_PUSH;
            st   <= S_IMM;
          end else begin
            st <= S_HALT;
          end
        end
        S_SEL: if (in_valid) begin
          if (sel_bad) begin
            st <= S_HALT;
          end else begin
            alu_op <= in_byte[5:3];
            dst    <= in_byte[2:0];
            to_mem <= (in_byte[7:6] == 2'b00);
            st     <= S_IMM;
          end
        end
        S_IMM: if (in_valid) begin
          imm <= {in_byte, imm[31:8]};
          cnt <= cnt + 2'd1;
          if (cnt == 2'd3) st <= S_EXEC;
        end
        S_EXEC: begin
          case (kind)
            K_MOV: begin
              if (to_mem) begin
                maddr <= rf[dst];
                wdat  <= imm;
                st    <= S_WB;
              end else begin
                rf[dst] <= imm;
                st      <= S_OP;
              end
            end
            K_PUSH: begin
              rf[SP_IDX] <= sp_dec;
              maddr      <= sp_dec;
              wdat       <= imm;
              st         <= S_WB;
            end
            default: begin
              if (to_mem) begin
                maddr <= rf[dst];
                st    <= S_RD;
              end else begin
                flag_s <= res[31];
                flag_z <= (res == 32'd0);
                flag_o <= ovf;
                if (alu_op != OP_CMP) rf[dst] <= res;
                st <= S_OP;
              end
            end
          endcase
        end
        S_RD: st <= S_RWAIT;
        S_RWAIT: begin
          flag_s <= res[31];
          flag_z <= (res == 32'd0);
          flag_o <= ovf;
          wdat   <= res;
          st     <= (alu_op == OP_CMP) ? S_OP : S_WB;
        end
        S_WB: st <= S_OP;
        default: st <= S_HALT;
      endcase
    end
  end

  a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  a_r11_fault_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !in_ready);
  a_r10_port_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);
  a_r3_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r5_cmp_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RWAIT && alu_op == OP_CMP) |=> !mem_req);
  a_r9_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && kind == K_PUSH) |-> (mem_addr == rf[SP_IDX]));

endmodule

// File: tb/imm_exec_core_tb.sv
module imm_exec_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  peek_sel = 3'd0;
  logic [31:0] peek_data;
  logic        flag_s, flag_z, flag_o, fault;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  int overlap = 0;
  int cyc = 0;

  logic        poke_en = 1'b0;
  logic [5:0]  poke_a = '0;
  logic [31:0] poke_d = '0;
  logic [31:0] mem [64];

  always #4 clk = ~clk;

  imm_exec_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .peek_sel(peek_sel), .peek_data(peek_data), .flag_s(flag_s),
    .flag_z(flag_z), .flag_o(flag_o), .fault(fault)
  );

  always @(posedge clk) begin
    if (poke_en) mem[poke_a] <= poke_d;
    else if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:2]];
    if (mem_req && mem_we) wr_count <= wr_count + 1;
    if (mem_req && in_ready) overlap <= overlap + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_imm(input logic [31:0] v);
    for (int i = 0; i < 4; i++) send(v[8*i +: 8]);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready && !fault) @(negedge clk);
  endtask

  task automatic peek(input logic [2:0] r, output logic [31:0] v);
    peek_sel = r;
    #1;
    v = peek_data;
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1;
    poke_a = addr[7:2];
    poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic set_reg(input logic [2:0] r, input logic [31:0] v);
    send({5'b10111, r});
    send_imm(v);
    wait_idle();
  endtask

  task automatic chk_flags(input string tag, input logic s, input logic z, input logic o);
    chk(tag, {29'd0, flag_s, flag_z, flag_o}, {29'd0, s, z, o});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      peek(r[2:0], v);
      chk("R12 register cleared", v, 32'd0);
    end
    chk_flags("R12 flags cleared", 1'b0, 1'b0, 1'b0);
    chk("R12 fault cleared", {31'd0, fault}, 32'd0);
    chk("R12 ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_copy_regs();
    logic [31:0] v;
    for (int r = 0; r < 8; r++) set_reg(r[2:0], 32'h0d0c0b0a + r);
    for (int r = 0; r < 8; r++) begin
      peek(r[2:0], v);
      chk("R1 R7 copy into register", v, 32'h0d0c0b0a + r);
    end
  endtask

  task automatic t_group_reg();
    logic [31:0] v;
    set_reg(3'd3, 32'd1);
    send(8'h81); send(8'hc3); send_imm(32'h0d0c0b0a); wait_idle();
    peek(3'd3, v);
    chk("R2 add to register", v, 32'h0d0c0b0b);
    chk_flags("R6 add flags", 1'b0, 1'b0, 1'b0);
    set_reg(3'd3, 32'd10);
    send(8'h81); send(8'heb); send_imm(32'd10); wait_idle();
    peek(3'd3, v);
    chk("R2 subtract to zero", v, 32'd0);
    chk_flags("R6 zero flag", 1'b0, 1'b1, 1'b0);
    set_reg(3'd6, 32'hd0c0b0a0);
    send(8'h81); send(8'hce); send_imm(32'h0d0c0b0a); wait_idle();
    peek(3'd6, v);
    chk("R2 or register", v, 32'hddccbbaa);
    chk_flags("R6 or sign flag", 1'b1, 1'b0, 1'b0);
    send(8'h81); send(8'hf6); send_imm(32'h0d0c0b0a); wait_idle();
    peek(3'd6, v);
    chk("R2 xor register", v, 32'hd0c0b0a0);
    send(8'h81); send(8'he6); send_imm(32'h0000ffff); wait_idle();
    peek(3'd6, v);
    chk("R2 and register", v, 32'h0000b0a0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    set_reg(3'd1, 32'h7fffffff);
    send(8'h81); send(8'hc1); send_imm(32'd1); wait_idle();
    peek(3'd1, v);
    chk("R6 add wraps", v, 32'h80000000);
    chk_flags("R6 add overflow", 1'b1, 1'b0, 1'b1);
    send(8'h35); send_imm(32'h00000001); wait_idle();
    chk_flags("R6 logic clears overflow", 1'b0, 1'b0, 1'b0);
    set_reg(3'd2, 32'h80000000);
    send(8'h81); send(8'hea); send_imm(32'd1); wait_idle();
    peek(3'd2, v);
    chk("R6 subtract wraps", v, 32'h7fffffff);
    chk_flags("R6 subtract overflow", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_short_forms();
    logic [31:0] v;
    set_reg(3'd0, 32'hd0c0b0a0);
    send(8'h0d); send_imm(32'h0d0c0b0a); wait_idle();
    peek(3'd0, v);
    chk("R4 short or on reg0", v, 32'hddccbbaa);
    set_reg(3'd0, 32'h000000ff);
    send(8'h25); send_imm(32'h0d0c0b0a); wait_idle();
    peek(3'd0, v);
    chk("R4 short and on reg0", v, 32'h0000000a);
    set_reg(3'd0, 32'h0d0c0baa);
    send(8'h2d); send_imm(32'h0d0c0b0a); wait_idle();
    peek(3'd0, v);
    chk("R4 short subtract on reg0", v, 32'h000000a0);
    set_reg(3'd0, 32'hddccb0a0);
    send(8'h35); send_imm(32'h0d0c0b0a); wait_idle();
    peek(3'd0, v);
    chk("R4 short xor on reg0", v, 32'hd0c0bbaa);
  endtask

  task automatic t_compare();
    logic [31:0] v;
    set_reg(3'd0, 32'h0d0c0b0a);
    send(8'h3d); send_imm(32'h0d0c0b07); wait_idle();
    chk_flags("R5 compare greater", 1'b0, 1'b0, 1'b0);
    peek(3'd0, v);
    chk("R5 compare keeps register", v, 32'h0d0c0b0a);
    send(8'h3d); send_imm(32'h0d0c0b0a); wait_idle();
    chk_flags("R5 compare equal", 1'b0, 1'b1, 1'b0);
    set_reg(3'd3, 32'h0d0c0b07);
    send(8'h81); send(8'hfb); send_imm(32'h0d0c0b0a); wait_idle();
    chk_flags("R5 compare lesser", 1'b1, 1'b0, 1'b0);
    set_reg(3'd0, 32'h80000000);
    send(8'h3d); send_imm(32'd1); wait_idle();
    chk_flags("R5 R6 compare overflow", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_memory();
    logic [31:0] v;
    int w0;
    set_reg(3'd3, 32'h60);
    poke(32'h60, 32'd1);
    send(8'h81); send(8'h03); send_imm(32'h0d0c0b0a); wait_idle();
    chk("R3 add to memory word", mem[24], 32'h0d0c0b0b);
    poke(32'h60, 32'd10);
    send(8'h81); send(8'h2b); send_imm(32'd1); wait_idle();
    chk("R3 subtract memory word", mem[24], 32'd9);
    poke(32'h60, 32'h0d0c0b07);
    w0 = wr_count;
    send(8'h81); send(8'h3b); send_imm(32'h0d0c0b0a); wait_idle();
    chk_flags("R5 compare memory lesser", 1'b1, 1'b0, 1'b0);
    chk("R5 compare memory no write", wr_count - w0, 32'd0);
    chk("R5 compare memory unchanged", mem[24], 32'h0d0c0b07);
    send(8'hc7); send(8'h3b); send_imm(32'h0d0c0b0a); wait_idle();
    chk("R8 copy to memory", mem[24], 32'h0d0c0b0a);
    send(8'hc7); send(8'hf9); send_imm(32'h12345678); wait_idle();
    peek(3'd1, v);
    chk("R8 copy to register ignores bits 5:3", v, 32'h12345678);
    set_reg(3'd4, 32'h14);
    send(8'h68); send_imm(32'h000000af); wait_idle();
    peek(3'd4, v);
    chk("R9 push lowers stack pointer", v, 32'h10);
    chk("R9 push stores immediate", mem[4], 32'h000000af);
    chk("R10 no memory access while ready", overlap, 32'd0);
  endtask

  task automatic t_faults();
    logic [31:0] v;
    set_reg(3'd5, 32'h55);
    send(8'h81); send(8'hd3);
    repeat (3) @(negedge clk);
    chk("R11 bad sub-op faults", {31'd0, fault}, 32'd1);
    chk("R11 not ready after fault", {31'd0, in_ready}, 32'd0);
    do_reset();
    @(negedge clk);
    peek(3'd5, v);
    chk("R12 reset clears after fault", v, 32'd0);
    chk("R12 fault cleared by reset", {31'd0, fault}, 32'd0);
    send(8'h90);
    repeat (2) @(negedge clk);
    chk("R11 unknown opcode faults", {31'd0, fault}, 32'd1);
    do_reset();
    send(8'hc7); send(8'h43);
    repeat (2) @(negedge clk);
    chk("R11 displacement selector faults", {31'd0, fault}, 32'd1);
    do_reset();
    send(8'h81); send(8'h04);
    repeat (2) @(negedge clk);
    chk("R11 index-byte selector faults", {31'd0, fault}, 32'd1);
    do_reset();
  endtask

  initial begin
    t_reset();
    t_copy_regs();
    t_group_reg();
    t_overflow();
    t_short_forms();
    t_compare();
    t_memory();
    t_faults();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule